// File: doc/BRIEF.md
# TDM Receive Deserializer with Port Select

This block turns one serial audio line into parallel sample words. The line comes from one of several input ports, chosen by a one-hot select register. A loopback mode can take the transmitter's own output line in place of the ports. The block tracks the bit clock as a level synchronous to the system clock, and it captures data on the edge that the polarity control picks. Frames are aligned to an external frame-sync line: a rising sync starts slot 0, either on the same capture edge or one capture edge later.

Within each slot, the first bits up to the programmed sample width are gathered, and any further bits in the slot are dropped. At the last bit of the slot, the sample is placed in the top bits of a 32-bit word with zeros below it. That word is delivered with a single-cycle valid strobe and its slot index, unless the slot mask marks the slot as ignored. After the last programmed slot the block waits for the next sync.

Top module: `tdm_rx_deser`

## Requirements
- R1: The input port is chosen by `cfg_port_sel`, one-hot: bit p set selects `port_data[p]`. Data on the other ports has no effect on the delivered words.
- R2: With `cfg_lsb_first`=0 the first received bit of a slot is the sample MSB. With 1 it is the sample LSB.
- R3: Slot width is coded on `cfg_slot_w` as 0=16, 1=20, 2=24, 3=32 bits. The number of slots per frame is `cfg_slots_m1`+1. Delivered slot indices never exceed `cfg_slots_m1`.
- R4: Sample width uses the same coding on `cfg_smp_w`, with sample width no greater than slot width. The sample occupies `out_word[31:32-w]` and the low 32-w bits are zero. Slot bits after the first w are discarded.
- R5: A slot whose bit in `cfg_slot_mask` is 1 produces no output word. A slot whose bit is 0 produces exactly one word.
- R6: A rising `fsync` seen at a capture edge starts the frame. With `cfg_bit_start`=0 the bit captured at that edge is bit 0 of slot 0. With 1, bit 0 is captured at the next capture edge.
- R7: With `cfg_pol`=1 data and sync are captured on the rising `bclk` edge. With 0 they are captured on the falling edge.
- R8: `out_valid` rises for exactly one clock, in the clock after the capture of a slot's last bit, together with `out_word` and `out_slot`.
- R9: With `cfg_no_fb`=1 the selected port is received. With 0 the `tx_loop` line is received instead.
- R10: While `ctl_rst` is high the framing state is cleared, and the block delivers nothing until a new sync arrives. While `ctl_en` is low no capture takes place.
- R11: After reset `out_valid` and `out_word` are 0.
- R12: After the last slot of a frame, further bits without a new sync rising edge produce no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_data | input | NPORTS | Serial data inputs, one per port |
| tx_loop | input | 1 | Transmitter output line used in loopback |
| bclk | input | 1 | Bit-clock level, synchronous to clk |
| fsync | input | 1 | Frame sync |
| ctl_en | input | 1 | Capture enable |
| ctl_rst | input | 1 | Framing reset |
| cfg_port_sel | input | NPORTS | One-hot port select |
| cfg_slots_m1 | input | 4 | Slots per frame minus one |
| cfg_slot_w | input | 2 | Slot width code |
| cfg_smp_w | input | 2 | Sample width code |
| cfg_pol | input | 1 | Capture edge: 1 rising, 0 falling |
| cfg_lsb_first | input | 1 | Bit order within a slot |
| cfg_bit_start | input | 1 | Delay from sync edge to bit 0 |
| cfg_no_fb | input | 1 | 1: receive port, 0: receive tx_loop |
| cfg_slot_mask | input | 16 | Set bit ignores that slot |
| out_valid | output | 1 | One-cycle word strobe |
| out_word | output | 32 | MSB-aligned sample word |
| out_slot | output | 4 | Slot index of out_word |

## Verification
Every word is due one clock after the capture edge of its slot's last bit, because one register sits between the bit-clock edge and the outputs. The bench changes `bclk` on falling clock edges and holds each level for two clocks. It reads the outputs on falling edges only, so a strobe is seen in the half-cycle after the register updates. A directed test checks that exact cycle and the cycle after it for the strobe (R8). Other checks compare the collected words and slot indices against a model of the requirements after trailing idle bit periods, by which time every word is due.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int WORD_W     = 32;
    localparam int SLOT_IDX_W = 4;
    localparam int NSLOT      = 2 ** SLOT_IDX_W;

    // width code: 0=16, 1=20, 2=24, 3=32
    function automatic logic [5:0] width_of(input logic [1:0] code);
        case (code)
            2'd0:    width_of = 6'd16;
            2'd1:    width_of = 6'd20;
            2'd2:    width_of = 6'd24;
            default: width_of = 6'd32;
        endcase
    endfunction

    typedef struct packed {
        logic                  fs;
        logic                  run;
        logic                  dly;
        logic [4:0]            bpos;
        logic [SLOT_IDX_W-1:0] slot;
        logic [WORD_W-1:0]     acc;
        logic [WORD_W-1:0]     word;
        logic [SLOT_IDX_W-1:0] wslot;
        logic                  valid;
    } rx_state_t;
endpackage

// File: rtl/rx_port_mux.sv
module rx_port_mux #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] data_i,
    input  logic [NPORTS-1:0] sel_i,
    output logic              data_o
);
    logic [NPORTS-1:0] gated;

    for (genvar p = 0; p < NPORTS; p++) begin : g_gate
        assign gated[p] = data_i[p] & sel_i[p];
    end

    assign data_o = |gated;

    // R1: selection must be one-hot (or empty)
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_i));
endmodule

// File: rtl/rx_bclk_edge.sv
module rx_bclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic pol,
    input  logic en,
    output logic cap
);
    logic bclk_d, bclk_q;

    always_comb begin
        bclk_d = bclk;
        cap    = en & (pol ? (bclk & ~bclk_q) : (~bclk & bclk_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_q <= 1'b0;
        else        bclk_q <= bclk_d;
    end

    // R7: a capture edge never occurs on two consecutive clocks
    p_cap_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> !cap);
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
    parameter int NPORTS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NPORTS-1:0]             port_data,
    input  logic                          tx_loop,
    input  logic                          bclk,
    input  logic                          fsync,
    input  logic                          ctl_en,
    input  logic                          ctl_rst,
    input  logic [NPORTS-1:0]             cfg_port_sel,
    input  logic [rxd_pkg::SLOT_IDX_W-1:0] cfg_slots_m1,
    input  logic [1:0]                    cfg_slot_w,
    input  logic [1:0]                    cfg_smp_w,
    input  logic                          cfg_pol,
    input  logic                          cfg_lsb_first,
    input  logic                          cfg_bit_start,
    input  logic                          cfg_no_fb,
    input  logic [rxd_pkg::NSLOT-1:0]     cfg_slot_mask,
    output logic                          out_valid,
    output logic [rxd_pkg::WORD_W-1:0]    out_word,
    output logic [rxd_pkg::SLOT_IDX_W-1:0] out_slot
);
    import rxd_pkg::*;

    logic      port_bit, rx_bit, cap;
    rx_state_t st_d, st_q;

    rx_port_mux #(.NPORTS(NPORTS)) u_mux (
        .clk    (clk),
        .rst_n  (rst_n),
        .data_i (port_data),
        .sel_i  (cfg_port_sel),
        .data_o (port_bit)
    );

    rx_bclk_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .bclk  (bclk),
        .pol   (cfg_pol),
        .en    (ctl_en),
        .cap   (cap)
    );

    assign rx_bit = cfg_no_fb ? port_bit : tx_loop;

    always_comb begin
        logic [5:0]            slot_bits, smp_bits;
        logic                  take, sync_rise;
        logic [4:0]            bp;
        logic [SLOT_IDX_W-1:0] sp;
        logic [WORD_W-1:0]     base, acc_n;

        st_d       = st_q;
        st_d.valid = 1'b0;
        slot_bits  = width_of(cfg_slot_w);
        smp_bits   = width_of(cfg_smp_w);
        take       = 1'b0;
        sync_rise  = fsync & ~st_q.fs;
        bp         = st_q.bpos;
        sp         = st_q.slot;
        base       = '0;
        acc_n      = st_q.acc;

        if (ctl_rst) begin
            st_d.fs   = 1'b0;
            st_d.run  = 1'b0;
            st_d.dly  = 1'b0;
            st_d.bpos = '0;
            st_d.slot = '0;
        end else if (cap) begin
            st_d.fs = fsync;
            if (sync_rise) begin
                if (cfg_bit_start) begin
                    st_d.dly = 1'b1;
                    st_d.run = 1'b0;
                end else begin
                    take = 1'b1;
                    bp   = '0;
                    sp   = '0;
                end
            end else if (st_q.dly) begin
                st_d.dly = 1'b0;
                take     = 1'b1;
                bp       = '0;
                sp       = '0;
            end else if (st_q.run) begin
                take = 1'b1;
            end

            if (take) begin
                base = (bp == 5'd0) ? '0 : st_q.acc;
                if (6'(bp) < smp_bits) begin
                    if (cfg_lsb_first) acc_n = base | (WORD_W'(rx_bit) << bp);
                    else               acc_n = {base[WORD_W-2:0], rx_bit};
                end else begin
                    acc_n = base;
                end
                st_d.acc = acc_n;

                if (6'(bp) == slot_bits - 6'd1) begin
                    if (!cfg_slot_mask[sp]) begin
                        st_d.valid = 1'b1;
                        st_d.word  = acc_n << (6'd32 - smp_bits);
                        st_d.wslot = sp;
                    end
                    st_d.bpos = '0;
                    st_d.slot = sp + 1'b1;
                    st_d.run  = (sp != cfg_slots_m1);
                end else begin
                    st_d.bpos = bp + 5'd1;
                    st_d.slot = sp;
                    st_d.run  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;
    assign out_slot  = st_q.wslot;

    // R8: strobe lasts one clock
    p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
    // R4: padding below a 16-bit or 24-bit sample is zero
    p_pad16_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_smp_w == 2'd0) |-> (out_word[15:0] == 16'h0));
    p_pad24_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_smp_w == 2'd2) |-> (out_word[7:0] == 8'h0));
    // R5: masked slots never appear
    p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cfg_slot_mask[out_slot]);
    // R3: slot index within the programmed count
    p_slot_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_slot <= cfg_slots_m1));
    // R10: framing reset and disable silence the output
    p_rst_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst |=> !out_valid);
    p_en_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |=> !out_valid);
endmodule

// File: tb/tdm_rx_deser_test.sv
`timescale 1ns/1ps
module tdm_rx_deser_test;
    localparam int NP = 4;

    typedef struct packed {
        logic        pol;
        logic        lsb;
        logic        bs;
        logic [1:0]  sw;
        logic [1:0]  mw;
        logic [3:0]  nm1;
        logic [15:0] mask;
        logic [1:0]  port;
        logic        nofb;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b1, 2'd3, 2'd3, 4'd1,  16'h0000, 2'd0, 1'b1, 32'hA5A51234},
        '{1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 4'd3,  16'h0000, 2'd2, 1'b1, 32'h0F0F3C3C},
        '{1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 4'd2,  16'h0002, 2'd1, 1'b1, 32'h12345678},
        '{1'b0, 1'b1, 1'b0, 2'd1, 2'd0, 4'd7,  16'h00AA, 2'd3, 1'b1, 32'hDEADBEEF},
        '{1'b1, 1'b0, 1'b1, 2'd3, 2'd2, 4'd0,  16'h0000, 2'd2, 1'b1, 32'hCAFEF00D},
        '{1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd15, 16'h8001, 2'd1, 1'b1, 32'h5A5A5A5A},
        '{1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 4'd1,  16'h0000, 2'd0, 1'b0, 32'h76543210}
    };

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] port_data = '0;
    logic          tx_loop = 1'b0, bclk = 1'b0, fsync = 1'b0;
    logic          ctl_en = 1'b0, ctl_rst = 1'b0;
    logic [NP-1:0] cfg_port_sel = 4'b0001;
    logic [3:0]    cfg_slots_m1 = '0;
    logic [1:0]    cfg_slot_w = '0, cfg_smp_w = '0;
    logic          cfg_pol = 1'b1, cfg_lsb_first = 1'b0, cfg_bit_start = 1'b0, cfg_no_fb = 1'b1;
    logic [15:0]   cfg_slot_mask = '0;
    logic          out_valid;
    logic [31:0]   out_word;
    logic [3:0]    out_slot;

    int n_tests = 0, n_fail = 0, got_n = 0;
    logic [31:0] got_word [256];
    logic [3:0]  got_slot [256];
    logic        prev_v = 1'b0;
    int          cur_port = 0;

    always #2.5 clk = ~clk;

    tdm_rx_deser #(.NPORTS(NP)) uut (.*);

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // collector, sampled away from the active edge
    always @(negedge clk) begin
        if (out_valid) begin
            got_word[got_n[7:0]] = out_word;
            got_slot[got_n[7:0]] = out_slot;
            got_n++;
        end
        if (rst_n && prev_v && out_valid) begin
            n_tests++; n_fail++;
            $display("FAIL R8: valid held two cycles, actual 1 expected 0");
        end
        prev_v = out_valid;
    end

    function automatic int wbits(input logic [1:0] c);
        case (c) 2'd0: return 16; 2'd1: return 20; 2'd2: return 24; default: return 32; endcase
    endfunction

    function automatic logic [31:0] slot_val(input vec_t v, input int s);
        logic [63:0] m;
        m = (64'd1 << wbits(v.sw)) - 64'd1;
        return (v.seed ^ (32'(s) * 32'h9E3779B9) ^ (32'(s) << 7)) & m[31:0];
    endfunction

    function automatic logic [31:0] exp_word(input vec_t v, input logic [31:0] val);
        logic [63:0] smp, m;
        int sw, mw;
        sw = wbits(v.sw); mw = wbits(v.mw);
        m = (64'd1 << mw) - 64'd1;
        smp = v.lsb ? ({32'd0, val} & m) : ({32'd0, val} >> (sw - mw));
        return 32'(smp << (32 - mw));
    endfunction

    task automatic apply_cfg(input vec_t v);
        cfg_pol = v.pol; cfg_lsb_first = v.lsb; cfg_bit_start = v.bs;
        cfg_slot_w = v.sw; cfg_smp_w = v.mw; cfg_slots_m1 = v.nm1;
        cfg_slot_mask = v.mask; cfg_port_sel = NP'(1) << v.port;
        cfg_no_fb = v.nofb; cur_port = int'(v.port);
    endtask

    task automatic drive_data(input logic d);
        port_data = {NP{~d}};
        if (cfg_no_fb) begin
            port_data[cur_port] = d;
            tx_loop = ~d;
        end else begin
            tx_loop = d;
        end
    endtask

    task automatic half(input logic lvl);
        bclk = lvl;
        repeat (2) @(negedge clk);
    endtask

    task automatic bit_period(input logic d, input logic fs);
        drive_data(d);
        fsync = fs;
        half(~cfg_pol);
        half(cfg_pol);
    endtask

    task automatic run_frame(input vec_t v, input bit do_sync);
        int sw;
        logic [31:0] val;
        apply_cfg(v);
        sw = wbits(v.sw);
        repeat (2) bit_period(1'b0, 1'b0);
        if (v.bs && do_sync) bit_period(1'b0, 1'b1);
        for (int s = 0; s <= int'(v.nm1); s++) begin
            val = slot_val(v, s);
            for (int b = 0; b < sw; b++)
                bit_period(v.lsb ? val[b] : val[sw-1-b],
                           do_sync && !v.bs && s == 0 && b == 0);
        end
        repeat (3) bit_period(1'b0, 1'b0);
    endtask

    task automatic check_frame(input vec_t v, input int base, input int vi);
        int k, expn;
        k = base; expn = 0;
        for (int s = 0; s <= int'(v.nm1); s++) if (!v.mask[s]) expn++;
        check(got_n - base == expn, $sformatf("R5 R3 word count, vector %0d", vi),
              32'(got_n - base), 32'(expn));
        for (int s = 0; s <= int'(v.nm1); s++) begin
            if (!v.mask[s] && k < got_n) begin
                check(got_slot[k[7:0]] == 4'(s), $sformatf("R3 R8 slot index, vector %0d", vi),
                      32'(got_slot[k[7:0]]), 32'(s));
                check(got_word[k[7:0]] == exp_word(v, slot_val(v, s)),
                      $sformatf("R1 R2 R4 R6 R7 R9 word, vector %0d slot %0d", vi, s),
                      got_word[k[7:0]], exp_word(v, slot_val(v, s)));
                k++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base;
        vec_t v;
        logic [31:0] val;
        repeat (4) @(negedge clk);
        // R11: reset state
        check(out_valid == 1'b0, "R11 valid after reset", 32'(out_valid), 0);
        check(out_word == 32'h0, "R11 word after reset", out_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        ctl_rst = 1'b1; @(negedge clk); ctl_rst = 1'b0;
        ctl_en = 1'b1;

        // table walk: R1 R2 R3 R4 R5 R6 R7 R9
        for (int i = 0; i < NV; i++) begin
            base = got_n;
            run_frame(VECS[i], 1'b1);
            check_frame(VECS[i], base, i);
        end

        // R8: strobe timing, one clock after the last capture edge
        v = '{1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd0, 16'h0, 2'd0, 1'b1, 32'h0000B00F};
        apply_cfg(v);
        val = slot_val(v, 0);
        repeat (2) bit_period(1'b0, 1'b0);
        for (int b = 0; b < 15; b++) bit_period(val[15-b], b == 0);
        drive_data(val[0]); fsync = 1'b0;
        half(1'b0);
        bclk = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b1, "R8 strobe due one clock after last capture", 32'(out_valid), 1);
        check(out_word == exp_word(v, val), "R8 word with strobe", out_word, exp_word(v, val));
        @(negedge clk);
        check(out_valid == 1'b0, "R8 strobe dropped next clock", 32'(out_valid), 0);
        repeat (2) bit_period(1'b0, 1'b0);

        // R10: disabled capture delivers nothing
        ctl_en = 1'b0;
        base = got_n;
        run_frame(VECS[1], 1'b1);
        check(got_n == base, "R10 no words while disabled", 32'(got_n - base), 0);
        ctl_en = 1'b1;

        // R10: framing reset mid-frame, rest of frame without sync
        v = VECS[0];
        apply_cfg(v);
        base = got_n;
        repeat (2) bit_period(1'b0, 1'b0);
        bit_period(1'b0, 1'b1);
        for (int b = 0; b < 5; b++) bit_period(1'b1, 1'b0);
        ctl_rst = 1'b1; @(negedge clk); ctl_rst = 1'b0;
        for (int b = 0; b < 64; b++) bit_period(b[0], 1'b0);
        check(got_n == base, "R10 no words after framing reset", 32'(got_n - base), 0);

        // R12: bits after the last slot without a new sync
        base = got_n;
        run_frame(VECS[4], 1'b1);
        for (int b = 0; b < 40; b++) bit_period(1'b1, 1'b0);
        check(got_n - base == 1, "R12 idle after frame end", 32'(got_n - base), 1);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule